// File: doc/BRIEF.md
# Raster-to-Tile Pixel Reorder Buffer

This block sits between a pixel source that delivers 24-bit RGB pixels in raster order and a consumer that wants the picture in 8x8 pixel tiles, such as a block compressor or a frame-sized FIFO. Incoming pixels are stored line after line into a band memory eight scan-lines tall. When a band of eight complete lines has been stored, the block reads it back one tile at a time. Tiles go from the left edge of the band to the right edge, and the pixels within each tile go row by row.

The memory has two eight-line banks that are used alternately. One band can be captured while the previous band is drained. The input stalls only when both banks hold bands that have not yet been read. Both sides are valid/ready streams. The input carries start-of-line and start-of-frame markers. The output marks the first pixel of every tile, and it marks the first pixel of the first tile of a frame. The line width is a parameter and must be a multiple of eight.

Top module: `raster_tile_reorder`

## Requirements
- R1: While reset is held and just after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Every 24-bit pixel value leaves the block unmodified, exactly once. No pixel is lost or repeated.
- R3: Within a tile, output order is tile row 0 columns 0..7, then tile row 1, and so on through tile row 7. Tile row r, column c of tile t is input line r of the band, pixel column 8*t+c.
- R4: Tiles of a band leave left to right, so tile t covers columns 8*t..8*t+7. Bands leave in the order they arrived. Input pixels arrive in raster order, with `in_sol` high only on column 0.
- R5: `out_sot` is 1 on the first pixel of each tile, meaning every 64th transfer counting from the first. It is 0 on all other pixels.
- R6: `out_sof` is 1 only on the first pixel of a band whose first input pixel (line 0, column 0) carried `in_sof`=1. It is 0 otherwise.
- R7: With the output stalled, the block accepts exactly two full bands (2*8*LINE_W pixels) and then drives `in_ready` to 0. `in_ready` returns to 1 only after a bank has been completely read out.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_sot` and `out_sof` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block can take an input pixel |
| in_data | input | 24 | Input RGB pixel |
| in_sol | input | 1 | Input pixel is column 0 of a line |
| in_sof | input | 1 | Input pixel is the first of a frame |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_data | output | 24 | Output RGB pixel |
| out_sot | output | 1 | Output pixel is first of a tile |
| out_sof | output | 1 | Output pixel is first of a frame |

## Verification
The bench builds the block with a 16-pixel line, so each band holds two tiles. Every pixel value encodes its band, line and column. The bench streams six bands, grouped into frames of two bands, and randomly stalls both sides. With this small width, every address of both banks is written and read several times, both tiles of every band are visited, and the wrap of the bank pointer is exercised repeatedly. Each output position is predicted arithmetically from its transfer index. A separate phase holds the output stalled to find the exact fill point of both banks and to confirm that the output holds still.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int TILE_DIM   = 8;
  localparam int TROW_W     = 3;
  localparam int TILE_PIX   = TILE_DIM * TILE_DIM;
  localparam int TPIX_W     = 6;
  localparam int NUM_BANKS  = 2;
endpackage

// File: rtl/rtt_band_ram.sv
module rtt_band_ram #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/rtt_wr_ctrl.sv
module rtt_wr_ctrl
  import rtt_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int COL_W  = 6,
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sol,
  input  logic                 in_sof,
  output logic                 in_ready,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  input  logic                 rd_done,
  input  logic                 rd_bank,
  output logic [NUM_BANKS-1:0] bank_full,
  output logic [NUM_BANKS-1:0] bank_sof
);
  logic              wbank;
  logic [TROW_W-1:0] wrow;
  logic [COL_W-1:0]  wcol;
  logic              line_end, band_end;

  assign in_ready = !bank_full[wbank];
  assign wr_en    = in_valid && in_ready;
  assign wr_addr  = {wbank, wrow, wcol};
  assign line_end = (wcol == COL_W'(LINE_W - 1));
  assign band_end = line_end && (wrow == TROW_W'(TILE_DIM - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wbank     <= 1'b0;
      wrow      <= '0;
      wcol      <= '0;
      bank_full <= '0;
      bank_sof  <= '0;
    end else begin
      if (wr_en) begin
        if (wcol == '0 && wrow == '0) bank_sof[wbank] <= in_sof;
        if (line_end) begin
          wcol <= '0;
          wrow <= band_end ? '0 : wrow + 1'b1;
        end else begin
          wcol <= wcol + 1'b1;
        end
        if (band_end) begin
          bank_full[wbank] <= 1'b1;
          wbank            <= ~wbank;
        end
      end
      if (rd_done) bank_full[rd_bank] <= 1'b0;
    end
  end

  assert_sol_col0_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_sol) |-> (wcol == '0));

  assert_done_only_full_R7: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> bank_full[rd_bank]);
endmodule

// File: rtl/rtt_rd_ctrl.sv
module rtt_rd_ctrl
  import rtt_pkg::*;
#(
  parameter int LINE_W = 64,
  parameter int COL_W  = 6,
  parameter int ADDR_W = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_BANKS-1:0] bank_full,
  input  logic [NUM_BANKS-1:0] bank_sof,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic                 out_sot,
  output logic                 out_sof,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_done,
  output logic                 rd_bank
);
  logic [TROW_W-1:0] trow, tcol;
  logic [COL_W-1:0]  base;
  logic              advance, tile_first, tile_last;

  assign advance    = !out_valid || out_ready;
  assign rd_en      = bank_full[rd_bank] && advance;
  assign rd_addr    = {rd_bank, trow, base + COL_W'(tcol)};
  assign tile_first = (trow == '0) && (tcol == '0);
  assign tile_last  = (trow == TROW_W'(TILE_DIM - 1)) && (tcol == TROW_W'(TILE_DIM - 1));
  assign rd_done    = rd_en && tile_last && (base == COL_W'(LINE_W - TILE_DIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_bank   <= 1'b0;
      trow      <= '0;
      tcol      <= '0;
      base      <= '0;
      out_valid <= 1'b0;
      out_sot   <= 1'b0;
      out_sof   <= 1'b0;
    end else begin
      if (advance) out_valid <= bank_full[rd_bank];
      if (rd_en) begin
        out_sot <= tile_first;
        out_sof <= tile_first && (base == '0) && bank_sof[rd_bank];
        tcol    <= tcol + 1'b1;
        if (tcol == TROW_W'(TILE_DIM - 1)) begin
          trow <= trow + 1'b1;
          if (tile_last) begin
            if (rd_done) begin
              base    <= '0;
              rd_bank <= ~rd_bank;
            end else begin
              base <= base + COL_W'(TILE_DIM);
            end
          end
        end
      end
    end
  end

  assert_sof_on_sot_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> out_sot);
endmodule

// File: rtl/raster_tile_reorder.sv
module raster_tile_reorder
  import rtt_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sol,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sot,
  output logic              out_sof
);
  localparam int COL_W  = (LINE_W > 1) ? $clog2(LINE_W) : 1;
  localparam int ADDR_W = 1 + TROW_W + COL_W;

  logic                 wr_en, rd_en, rd_done, rd_bank;
  logic [ADDR_W-1:0]    wr_addr, rd_addr;
  logic [NUM_BANKS-1:0] bank_full, bank_sof;

  rtt_wr_ctrl #(.LINE_W(LINE_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_done(rd_done), .rd_bank(rd_bank), .bank_full(bank_full),
    .bank_sof(bank_sof)
  );

  rtt_band_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(out_data)
  );

  rtt_rd_ctrl #(.LINE_W(LINE_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst(rst), .bank_full(bank_full), .bank_sof(bank_sof),
    .out_ready(out_ready), .out_valid(out_valid), .out_sot(out_sot),
    .out_sof(out_sof), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_bank(rd_bank)
  );

  // Transfer counter inside a tile, kept only for the tile-marker check.
  logic [TPIX_W-1:0] beat_cnt;
  always_ff @(posedge clk) begin
    if (rst) beat_cnt <= '0;
    else if (out_valid && out_ready) beat_cnt <= beat_cnt + 1'b1;
  end

  assert_sot_first_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && beat_cnt == '0) |-> out_sot);

  assert_sot_only_first_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && beat_cnt != '0) |-> !out_sot);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_sot) && $stable(out_sof)));

  assert_ready_after_drain_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(rd_done));
endmodule

// File: tb/raster_tile_reorder_tb_top.sv
module raster_tile_reorder_tb_top;
  localparam int LW       = 16;
  localparam int BAND_PIX = 8 * LW;
  localparam int NBANDS   = 6;
  localparam int TOTAL    = NBANDS * BAND_PIX;
  localparam int LIMIT    = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [23:0] in_data = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid, out_sot, out_sof;
  logic [23:0] out_data;

  int checks = 0, failures = 0;
  int in_idx = 0, out_idx = 0, cyc = 0;
  bit fire = 1'b0;

  always #10 clk = ~clk;

  raster_tile_reorder #(.DATA_W(24), .LINE_W(LW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sot(out_sot), .out_sof(out_sof)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit in_always, input bit out_en);
    @(negedge clk);
    cyc++;
    if (fire) in_idx++;
    out_ready = out_en && ($urandom % 4 != 0);
    if (out_valid && out_ready) begin
      int band = out_idx / BAND_PIX;
      int m    = out_idx % BAND_PIX;
      int r    = (m % 64) / 8;
      int col  = (m / 64) * 8 + (m % 8);
      logic [23:0] exp_d = {8'(band), 8'(r), 8'(col)};
      // R2 R3 R4: value and position of every pixel
      check(out_data == exp_d, "R2 R3 R4 data", out_data, exp_d);
      check(out_sot == (m % 64 == 0), "R5 sot", out_sot, (m % 64 == 0));
      check(out_sof == (m == 0 && band % 2 == 0), "R6 sof", out_sof,
            (m == 0 && band % 2 == 0));
      out_idx++;
    end
    in_valid = (in_idx < TOTAL) && (in_always || ($urandom % 3 != 0));
    begin
      int b = in_idx / BAND_PIX;
      int r = (in_idx / LW) % 8;
      int c = in_idx % LW;
      in_data = {8'(b), 8'(r), 8'(c)};
      in_sol  = (c == 0);
      in_sof  = (c == 0) && (r == 0) && (b % 2 == 0);
    end
    #1 fire = in_valid && in_ready;
  endtask

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R7: output stalled, both banks fill, then input stalls
    for (int i = 0; i < 3 * BAND_PIX; i++) step(1'b1, 1'b0);
    check(in_idx == 2 * BAND_PIX, "R7 accepted count", in_idx, 2 * BAND_PIX);
    check(in_ready == 1'b0, "R7 in_ready when full", in_ready, 0);
    check(out_valid == 1'b1, "R8 out_valid stalled", out_valid, 1);
    held = out_data;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    check(out_valid == 1'b1 && out_data == held, "R8 hold under stall", out_data, held);
    check(out_sot == 1'b1, "R5 held first pixel sot", out_sot, 1);
    check(in_idx == 2 * BAND_PIX, "R7 no extra accept", in_idx, 2 * BAND_PIX);

    // Main run with random stalls on both sides
    while (out_idx < TOTAL && cyc < LIMIT) step(1'b0, 1'b1);
    if (cyc >= LIMIT) begin
      failures++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", out_idx, TOTAL);
    end
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1);
    check(out_idx == TOTAL, "R2 output count", out_idx, TOTAL);
    check(in_idx == TOTAL, "R2 input count", in_idx, TOTAL);
    check(out_valid == 1'b0, "R2 no extra output", out_valid, 0);
    check(in_ready == 1'b1, "R7 ready after drain", in_ready, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule